// File: doc/BRIEF.md
# Broadcast Invalidate Initiator with Response Counting

This block sits in a memory-side cache controller and drives the invalidation of one cache line when the line has too many copies to track one by one. A start request hands it a line index, the number of copies believed to exist in the first-level caches, and a transaction index. The block sends exactly one write flit to the fixed broadcast address. The line index travels in the data field. The network copies this flit to every first-level cache.

Only caches that hold a copy answer. A cache that holds the line in both its instruction and its data array answers twice. The block therefore counts response flits that carry the transaction index. It declares completion when the count equals the recorded copy count. Up to four such transactions can be in flight, each held in its own slot and told apart by transaction index.

The caller must keep transaction indices unique among the transactions in flight.

Top module: `bcast_inval_initiator`

## Requirements
- R1: After a synchronous active-low reset, `start_ready` is 1 and `cmd_valid`, `done_valid` and `err_unmatched` are 0.
- R2: Every accepted start produces exactly one command flit with these fields: `cmd_code` = 2'b10 (write), `cmd_addr` = 3 (bits 0 and 1 set, all others clear), `cmd_wdata` = the line index zero-extended, and `cmd_trdid` = the start's transaction index. The flit appears the cycle after the start is accepted. It is held unchanged while `cmd_ready` is 0.
- R3: `start_ready` is 1 only when two conditions hold: a slot is free, and the command register is either empty or being taken in the same cycle (`cmd_ready` = 1). A start is accepted when `start_valid` and `start_ready` are both 1.
- R4: There are four slots, and each accepted start takes the lowest-numbered free slot. While all four slots are busy, `start_ready` is 0 and a start is refused.
- R5: A response counts toward a busy slot when all three conditions hold:
  - `rsp_valid` is 1;
  - `rsp_trdid` equals the slot's transaction index;
  - the slot's count is below its expected copy count.
  Such responses may arrive in any cycles, before or after the command flit is taken.
- R6: A slot is complete once its command flit has been taken and its count equals its expected count. Completion is reported as a one-cycle pulse of `done_valid` with `done_trdid` set to the slot's transaction index. If the completing response or handshake happens in cycle k, the pulse is in cycle k+2. The slot is free from that pulse cycle on.
- R7: With an expected count of 0, `done_valid` pulses in cycle k+2, where k is the cycle of the command handshake.
- R8: When several slots are complete, one is reported per cycle, lowest-numbered slot first. The others wait without being lost.
- R9: A valid response that counts toward no slot under R5 changes no count. It raises `err_unmatched` for exactly the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Start request present |
| start_ready | output | 1 | Start request can be accepted |
| start_line | input | LINE_W | Line index to invalidate |
| start_copies | input | CNT_W | Number of copies expected to answer |
| start_trdid | input | TRDID_W | Transaction index of the request |
| cmd_valid | output | 1 | Command flit present |
| cmd_ready | input | 1 | Network takes the command flit |
| cmd_addr | output | ADDR_W | Broadcast address, value 3 |
| cmd_code | output | 2 | Command code, write = 2'b10 |
| cmd_wdata | output | DATA_W | Line index, zero-extended |
| cmd_trdid | output | TRDID_W | Transaction index of the flit |
| rsp_valid | input | 1 | Response flit present |
| rsp_trdid | input | TRDID_W | Transaction index of the response |
| done_valid | output | 1 | One-cycle completion pulse |
| done_trdid | output | TRDID_W | Transaction index that completed |
| err_unmatched | output | 1 | Previous-cycle response matched no slot |

## Verification
A slot with zero expected copies becomes complete on its command handshake. That can happen in the same cycle as the last response of an earlier slot. The bench provokes this by starting two transactions back to back: copy count 1 on the first and 0 on the second. It then raises `cmd_ready` for the second flit in the same cycle that it delivers the first transaction's only response. A behavioural per-cycle model, holding slots as plain integer arrays, predicts two completion pulses in consecutive cycles, lower slot first. Every output is compared against it on every clock.

// File: rtl/bii_pkg.sv
// Package: shared constants of the broadcast invalidate initiator.
// Assumes: the command code and broadcast address are fixed by the
// coherence network and never change at run time.
package bii_pkg;
    localparam int          CMD_W      = 2;
    localparam logic [1:0]  CMD_WRITE  = 2'b10;
    localparam logic [1:0]  BCAST_ADDR = 2'b11;
endpackage

// File: rtl/bii_pick_low.sv
// Module: fixed-priority picker, lowest request index wins.
// Assumes: nothing about the request pattern; output grant is one-hot or zero.
module bii_pick_low #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o,
    output logic         any_o
);
    // Scan from the top so that the lowest set bit is the last one written.
    always_comb begin
        gnt_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o    = '0;
                gnt_o[i] = 1'b1;
            end
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/bii_slot.sv
// Module: one outstanding broadcast transaction.
// It holds the transaction index, the expected copy count, the number of
// responses received so far and whether the command flit has left.
// Assumes: alloc_i is only raised while the slot is free, and release_i only
// while finish_o is high.
module bii_slot #(
    parameter int TRDID_W = 4,
    parameter int CNT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_i,
    input  logic [TRDID_W-1:0] alloc_trdid_i,
    input  logic [CNT_W-1:0]   alloc_copies_i,
    input  logic               sent_set_i,
    input  logic               rsp_valid_i,
    input  logic [TRDID_W-1:0] rsp_trdid_i,
    input  logic               count_i,
    input  logic               release_i,
    output logic               busy_o,
    output logic               match_o,
    output logic               finish_o,
    output logic [TRDID_W-1:0] trdid_o
);
    logic               busy_q;
    logic               sent_q;
    logic [TRDID_W-1:0] trd_q;
    logic [CNT_W-1:0]   exp_q;
    logic [CNT_W-1:0]   cnt_q;

    // A response belongs here if the index matches and copies remain.
    always_comb begin
        match_o  = busy_q && rsp_valid_i && (trd_q == rsp_trdid_i) && (cnt_q < exp_q);
        finish_o = busy_q && sent_q && (cnt_q == exp_q);
        busy_o   = busy_q;
        trdid_o  = trd_q;
    end

    // Slot bookkeeping: allocate, mark sent, count responses, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
            trd_q  <= '0;
            exp_q  <= '0;
            cnt_q  <= '0;
        end else if (release_i) begin
            busy_q <= 1'b0;
            sent_q <= 1'b0;
        end else if (alloc_i) begin
            busy_q <= 1'b1;
            sent_q <= 1'b0;
            trd_q  <= alloc_trdid_i;
            exp_q  <= alloc_copies_i;
            cnt_q  <= '0;
        end else begin
            if (sent_set_i) begin
                sent_q <= 1'b1;
            end
            if (count_i) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bii_cmd_reg.sv
// Module: single-entry output register for the broadcast command flit.
// Assumes: load_i is only raised when the register is empty or being taken.
module bii_cmd_reg #(
    parameter int LINE_W  = 34,
    parameter int DATA_W  = 64,
    parameter int TRDID_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [LINE_W-1:0]  line_i,
    input  logic [TRDID_W-1:0] trdid_i,
    input  logic               take_i,
    output logic               valid_o,
    output logic [DATA_W-1:0]  wdata_o,
    output logic [TRDID_W-1:0] trdid_o
);
    logic               valid_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [TRDID_W-1:0] trdid_q;

    // Hold the flit until the network takes it; reload on a new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            wdata_q <= '0;
            trdid_q <= '0;
        end else if (load_i) begin
            valid_q <= 1'b1;
            wdata_q <= DATA_W'(line_i);
            trdid_q <= trdid_i;
        end else if (take_i) begin
            valid_q <= 1'b0;
        end
    end

    // Drive the registered flit fields out.
    always_comb begin
        valid_o = valid_q;
        wdata_o = wdata_q;
        trdid_o = trdid_q;
    end
endmodule

// File: rtl/bcast_inval_initiator.sv
// Module: broadcast invalidate initiator (top).
// It accepts start requests into one of N_SLOTS slots and sends one broadcast
// write flit per request. It counts the responses that return for each slot
// and pulses done when a slot's count reaches its expected copy count.
// Assumes: transaction indices of in-flight requests are unique, and
// DATA_W >= LINE_W.
module bcast_inval_initiator
    import bii_pkg::*;
#(
    parameter int LINE_W  = 34,
    parameter int DATA_W  = 64,
    parameter int ADDR_W  = 40,
    parameter int TRDID_W = 4,
    parameter int CNT_W   = 8,
    parameter int N_SLOTS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_valid,
    output logic               start_ready,
    input  logic [LINE_W-1:0]  start_line,
    input  logic [CNT_W-1:0]   start_copies,
    input  logic [TRDID_W-1:0] start_trdid,
    output logic               cmd_valid,
    input  logic               cmd_ready,
    output logic [ADDR_W-1:0]  cmd_addr,
    output logic [CMD_W-1:0]   cmd_code,
    output logic [DATA_W-1:0]  cmd_wdata,
    output logic [TRDID_W-1:0] cmd_trdid,
    input  logic               rsp_valid,
    input  logic [TRDID_W-1:0] rsp_trdid,
    output logic               done_valid,
    output logic [TRDID_W-1:0] done_trdid,
    output logic               err_unmatched
);
    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [N_SLOTS-1:0] slot_busy;
    logic [N_SLOTS-1:0] slot_match;
    logic [N_SLOTS-1:0] slot_finish;
    logic [N_SLOTS-1:0] alloc_gnt;
    logic [N_SLOTS-1:0] hit_gnt;
    logic [N_SLOTS-1:0] fin_gnt;
    logic [TRDID_W-1:0] slot_trd [N_SLOTS];
    logic               any_free;
    logic               any_hit;
    logic               any_fin;
    logic [IDX_W-1:0]   alloc_idx;
    logic [IDX_W-1:0]   fin_idx;
    logic [IDX_W-1:0]   cmd_slot_q;
    logic               start_fire;
    logic               cmd_fire;
    logic               cmd_valid_w;

    // Choose the lowest free slot for a new request.
    bii_pick_low #(.N(N_SLOTS)) u_alloc_pick (
        .req_i (~slot_busy),
        .gnt_o (alloc_gnt),
        .any_o (any_free)
    );

    // Choose the slot a response counts toward (unique by assumption).
    bii_pick_low #(.N(N_SLOTS)) u_hit_pick (
        .req_i (slot_match),
        .gnt_o (hit_gnt),
        .any_o (any_hit)
    );

    // Choose which complete slot is reported this cycle.
    bii_pick_low #(.N(N_SLOTS)) u_fin_pick (
        .req_i (slot_finish),
        .gnt_o (fin_gnt),
        .any_o (any_fin)
    );

    // Turn the one-hot allocation and finish grants into indices.
    always_comb begin
        alloc_idx = '0;
        fin_idx   = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (alloc_gnt[i]) alloc_idx = IDX_W'(i);
            if (fin_gnt[i])   fin_idx   = IDX_W'(i);
        end
    end

    // Start and command handshakes.
    always_comb begin
        start_ready = any_free && (!cmd_valid_w || cmd_ready);
        start_fire  = start_valid && start_ready;
        cmd_fire    = cmd_valid_w && cmd_ready;
    end

    // Remember which slot owns the flit in the command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_slot_q <= '0;
        end else if (start_fire) begin
            cmd_slot_q <= alloc_idx;
        end
    end

    bii_cmd_reg #(
        .LINE_W  (LINE_W),
        .DATA_W  (DATA_W),
        .TRDID_W (TRDID_W)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_fire),
        .line_i  (start_line),
        .trdid_i (start_trdid),
        .take_i  (cmd_ready),
        .valid_o (cmd_valid_w),
        .wdata_o (cmd_wdata),
        .trdid_o (cmd_trdid)
    );

    // Fixed command fields of the broadcast flit.
    always_comb begin
        cmd_valid = cmd_valid_w;
        cmd_addr  = ADDR_W'(BCAST_ADDR);
        cmd_code  = CMD_WRITE;
    end

    // One slot per in-flight transaction.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        bii_slot #(
            .TRDID_W (TRDID_W),
            .CNT_W   (CNT_W)
        ) u_slot (
            .clk            (clk),
            .rst_n          (rst_n),
            .alloc_i        (start_fire && alloc_gnt[g]),
            .alloc_trdid_i  (start_trdid),
            .alloc_copies_i (start_copies),
            .sent_set_i     (cmd_fire && (cmd_slot_q == IDX_W'(g))),
            .rsp_valid_i    (rsp_valid),
            .rsp_trdid_i    (rsp_trdid),
            .count_i        (hit_gnt[g]),
            .release_i      (fin_gnt[g]),
            .busy_o         (slot_busy[g]),
            .match_o        (slot_match[g]),
            .finish_o       (slot_finish[g]),
            .trdid_o        (slot_trd[g])
        );
    end

    // Registered completion pulse and unmatched-response flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid    <= 1'b0;
            done_trdid    <= '0;
            err_unmatched <= 1'b0;
        end else begin
            done_valid    <= any_fin;
            if (any_fin) begin
                done_trdid <= slot_trd[fin_idx];
            end
            err_unmatched <= rsp_valid && !any_hit;
        end
    end
endmodule

// File: rtl/bii_checker.sv
// Module: assertion checker for the broadcast invalidate initiator.
// It is attached to the top by the bind below and only observes.
module bii_checker #(
    parameter int DATA_W  = 64,
    parameter int TRDID_W = 4,
    parameter int N_SLOTS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_ready,
    input logic               cmd_valid,
    input logic               cmd_ready,
    input logic [DATA_W-1:0]  cmd_wdata,
    input logic [TRDID_W-1:0] cmd_trdid,
    input logic               rsp_valid,
    input logic               done_valid,
    input logic               err_unmatched,
    input logic [N_SLOTS-1:0] slot_busy,
    input logic [N_SLOTS-1:0] fin_gnt
);
    // R2: a stalled flit stays put with the same fields.
    p_cmd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_wdata) && $stable(cmd_trdid));

    // R4: no start can be accepted while every slot is busy.
    p_full_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&slot_busy) |-> !start_ready);

    // R8: at most one slot is released per cycle.
    p_one_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fin_gnt));

    // R6: a done pulse follows a slot release in the previous cycle.
    p_done_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(|fin_gnt));

    // R9: the error flag follows a valid response in the previous cycle.
    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_unmatched |-> $past(rsp_valid));
endmodule

bind bcast_inval_initiator bii_checker #(
    .DATA_W  (DATA_W),
    .TRDID_W (TRDID_W),
    .N_SLOTS (N_SLOTS)
) u_bii_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_ready   (start_ready),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_wdata     (cmd_wdata),
    .cmd_trdid     (cmd_trdid),
    .rsp_valid     (rsp_valid),
    .done_valid    (done_valid),
    .err_unmatched (err_unmatched),
    .slot_busy     (slot_busy),
    .fin_gnt       (fin_gnt)
);

// File: tb/bcast_inval_initiator_tb_top.sv
module bcast_inval_initiator_tb_top;
    localparam int LINE_W = 34, DATA_W = 64, ADDR_W = 40, TRDID_W = 4, CNT_W = 8, NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic start_ready;
    logic [LINE_W-1:0] start_line = '0;
    logic [CNT_W-1:0] start_copies = '0;
    logic [TRDID_W-1:0] start_trdid = '0;
    logic cmd_valid;
    logic cmd_ready = 1'b1;
    logic [ADDR_W-1:0] cmd_addr;
    logic [1:0] cmd_code;
    logic [DATA_W-1:0] cmd_wdata;
    logic [TRDID_W-1:0] cmd_trdid;
    logic rsp_valid = 1'b0;
    logic [TRDID_W-1:0] rsp_trdid = '0;
    logic done_valid;
    logic [TRDID_W-1:0] done_trdid;
    logic err_unmatched;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    bcast_inval_initiator dut_i (
        .clk(clk), .rst_n(rst_n),
        .start_valid(start_valid), .start_ready(start_ready),
        .start_line(start_line), .start_copies(start_copies), .start_trdid(start_trdid),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
        .cmd_code(cmd_code), .cmd_wdata(cmd_wdata), .cmd_trdid(cmd_trdid),
        .rsp_valid(rsp_valid), .rsp_trdid(rsp_trdid),
        .done_valid(done_valid), .done_trdid(done_trdid), .err_unmatched(err_unmatched)
    );

    // ---------------- behavioural reference model ----------------
    int m_busy [NS];
    int m_sent [NS];
    int m_exp  [NS];
    int m_cnt  [NS];
    int m_trd  [NS];
    int m_cv, m_cline_lo, m_cline_hi, m_ctrd, m_cslot;
    int m_done, m_dtrd, m_err;
    longint m_cline;

    function automatic int m_rdy();
        int free = 0;
        for (int i = 0; i < NS; i++) if (m_busy[i] == 0) free = 1;
        return (free != 0 && (m_cv == 0 || cmd_ready)) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_busy[i] = 0; m_sent[i] = 0; m_exp[i] = 0; m_cnt[i] = 0; m_trd[i] = 0;
            end
            m_cv = 0; m_cline = 0; m_ctrd = 0; m_cslot = 0;
            m_done = 0; m_dtrd = 0; m_err = 0;
        end else begin
            int sfire, cfire, hit, fin, al;
            sfire = (start_valid && m_rdy() != 0) ? 1 : 0;
            cfire = (m_cv != 0 && cmd_ready) ? 1 : 0;
            hit = -1; fin = -1; al = -1;
            for (int i = 0; i < NS; i++) begin
                if (hit < 0 && rsp_valid && m_busy[i] != 0 && m_trd[i] == int'(rsp_trdid)
                    && m_cnt[i] < m_exp[i]) hit = i;
                if (fin < 0 && m_busy[i] != 0 && m_sent[i] != 0 && m_cnt[i] == m_exp[i]) fin = i;
                if (al < 0 && m_busy[i] == 0) al = i;
            end
            m_err = (rsp_valid && hit < 0) ? 1 : 0;
            if (hit >= 0) m_cnt[hit]++;
            m_done = (fin >= 0) ? 1 : 0;
            if (fin >= 0) begin m_dtrd = m_trd[fin]; m_busy[fin] = 0; m_sent[fin] = 0; end
            if (cfire != 0) m_sent[m_cslot] = 1;
            if (sfire != 0) begin
                m_busy[al] = 1; m_sent[al] = 0; m_cnt[al] = 0;
                m_exp[al] = int'(start_copies); m_trd[al] = int'(start_trdid);
                m_cv = 1; m_cline = longint'(start_line); m_ctrd = int'(start_trdid); m_cslot = al;
            end else if (cfire != 0) begin
                m_cv = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison, away from the active edge.
    int dq [$];
    int err_seen = 0;
    always @(negedge clk) begin
        #5;
        if (rst_n && !finished) begin
            chk(start_ready == m_rdy()[0], "R3", "start_ready", start_ready, m_rdy());
            chk(cmd_valid == m_cv[0], "R2", "cmd_valid", cmd_valid, m_cv);
            if (cmd_valid && m_cv != 0) begin
                chk(cmd_addr == ADDR_W'(3) && cmd_code == 2'b10, "R2", "addr/code",
                    {cmd_addr, cmd_code}, {ADDR_W'(3), 2'b10});
                chk(cmd_wdata == DATA_W'(m_cline), "R2", "cmd_wdata", cmd_wdata, m_cline);
                chk(int'(cmd_trdid) == m_ctrd, "R2", "cmd_trdid", cmd_trdid, m_ctrd);
            end
            chk(done_valid == m_done[0], "R6", "done_valid", done_valid, m_done);
            if (done_valid && m_done != 0)
                chk(int'(done_trdid) == m_dtrd, "R6", "done_trdid", done_trdid, m_dtrd);
            chk(err_unmatched == m_err[0], "R9", "err_unmatched", err_unmatched, m_err);
            if (done_valid) dq.push_back(int'(done_trdid));
            if (err_unmatched) err_seen++;
        end
    end

    task automatic cyc(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic start(input longint line, input int copies, input int trd);
        start_valid = 1'b1; start_line = LINE_W'(line);
        start_copies = CNT_W'(copies); start_trdid = TRDID_W'(trd);
        cyc(); start_valid = 1'b0;
    endtask

    task automatic rsp(input int trd);
        rsp_valid = 1'b1; rsp_trdid = TRDID_W'(trd);
        cyc(); rsp_valid = 1'b0;
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        #5;
        // R1: reset state
        chk(start_ready && !cmd_valid && !done_valid && !err_unmatched, "R1", "reset outputs",
            {start_ready, cmd_valid, done_valid, err_unmatched}, 4'b1000);
        cyc();

        // R5/R6: three copies, one cache answering twice
        dq.delete();
        start(64'h3_2345_6789, 3, 5);
        cyc(2); rsp(5); rsp(5); cyc(1); rsp(5); cyc(4);
        chk(dq.size() == 1 && dq[0] == 5, "R5", "done after three responses", dq.size(), 1);

        // R7: zero copies complete after the handshake
        dq.delete();
        start(64'h0_0000_0abc, 0, 7);
        cyc(4);
        chk(dq.size() == 1 && dq[0] == 7, "R7", "zero-copy completion", dq.size(), 1);

        // R2/R3/R5: stalled flit, refused start, response before handshake
        dq.delete();
        cmd_ready = 1'b0;
        start(64'h1_ffff_0001, 1, 3);
        start_valid = 1'b1; start_line = '1; start_copies = 8'd1; start_trdid = 4'd4;
        cyc(); start_valid = 1'b0;
        rsp(3); cyc(3);
        chk(dq.size() == 0, "R5", "no done before handshake", dq.size(), 0);
        cmd_ready = 1'b1; cyc(4);
        chk(dq.size() == 1 && dq[0] == 3, "R3", "refused start left no trace", dq.size(), 1);

        // R4: fill all slots, fifth refused
        dq.delete();
        for (int t = 8; t < 12; t++) start(64'(t) << 20, 2, t);
        start_valid = 1'b1; start_line = 34'h5; start_copies = 8'd1; start_trdid = 4'd12;
        cyc(); #5;
        chk(start_ready == 1'b0, "R4", "start_ready while full", start_ready, 0);
        cyc(2); start_valid = 1'b0;
        for (int t = 11; t >= 8; t--) begin rsp(t); rsp(t); end
        cyc(4);
        chk(dq.size() == 4, "R4", "all four slots complete", dq.size(), 4);

        // R9: unknown index and excess response
        err_seen = 0;
        rsp(14); cyc();
        start(64'h77, 1, 6); cyc(1); rsp(6); rsp(6); cyc(3);
        chk(err_seen == 2, "R9", "unmatched responses flagged", err_seen, 2);

        // R8: zero-copy handshake and last response of another slot in one cycle
        dq.delete();
        start_valid = 1'b1; start_line = 34'h11; start_copies = 8'd1; start_trdid = 4'd1;
        cyc();
        start_line = 34'h22; start_copies = 8'd0; start_trdid = 4'd2;
        cyc(); start_valid = 1'b0;
        rsp(1);
        cyc(4);
        chk(dq.size() == 2 && dq[0] == 1 && dq[1] == 2, "R8", "ordered back-to-back done",
            dq.size() == 2 ? dq[0] * 16 + dq[1] : dq.size(), 8'h12);

        cyc(2);
        summary();
    end
endmodule